// File: doc/BRIEF.md
# Multi-Domain Time-of-Day Counter

This block keeps several independent time-of-day clocks for a packet switch. Each clock, called a domain, holds a seconds count and a nanoseconds count. On every core clock cycle an enabled domain advances by a programmable increment. The increment is a 64-bit fixed-point number of nanoseconds with 59 fraction bits. The fraction is kept in an accumulator, so sub-nanosecond remainders are never lost. When the nanoseconds count reaches one billion, it wraps and carries into the seconds count.

Software reaches the block through a simple word-wide register port, with single-cycle writes and a combinational read. It writes each domain's increment as two 32-bit halves, and a per-domain hold bit lets it stage a new increment without the domain seeing a half-written value.

A single access channel acts as a small command engine against a chosen domain:
- load a new time from its staging registers;
- capture (save) a domain's current time into those same registers;
- add a signed nanosecond delta.

A load is accepted only when the channel was idle before it, which keeps a stray repeated write from reloading the time.

Top module: `ptp_tod_core`

## Requirements
- R1: After reset every domain reads time 0 and is stopped, the control word and the command word read 0, and each domain's increment words read the nominal increment (default 0x0FF8000000000000: low word 0x00000000, high word 0x0FF80000).
- R2: Every cycle an enabled domain adds its increment, whose bits 63:59 are whole nanoseconds and bits 58:0 a fraction. The fraction accumulates exactly, so an increment of 2.5 ns gives 7 ns after 3 cycles and 10 ns after 4.
- R3: When the nanoseconds value would reach or pass 1,000,000,000, it is reduced by 1,000,000,000 and seconds increment in the same cycle, including a carry across the 32-bit boundary of the seconds count. Nanoseconds never hold 1,000,000,000 or more.
- R4: Control word (address 0x00) bits 2:0 enable domains 0..2 independently. A disabled domain keeps its time.
- R5: Control word bits 10:8 are per-domain hold bits. While a domain's hold bit is set, writes to its increment words (address 0x08+2d low word, 0x09+2d high word) are staged and read back, but the domain keeps counting with its previous increment. The staged value takes effect once the bit is cleared.
- R6: The command word (address 0x01) decodes as follows:
  - bits 2:0 are the action: 0 idle, 1 load, 2 save, 3 clock, 4 delta, 5 time-of-day;
  - bits 5:4 select the domain;
  - bit 8 is a sync flag.
  The action runs on the write. Actions 3 and 5 and the sync flag leave every domain's time unchanged, and a domain select of 3 leaves every domain untouched. The command word reads back as written.
- R7: A load copies the staging seconds (address 0x02 bits 15:0 for seconds 47:32, address 0x03 for seconds 31:0) and nanoseconds (address 0x04) into the selected domain and clears its fraction. A load is ignored unless the previous command action was idle.
- R8: A loaded nanoseconds value from 0x3FFFFFF0 to 0x3FFFFFFF is taken as a small negative offset. The domain becomes seconds minus 1, with nanoseconds of 999,999,984 plus the value's low four bits.
- R9: A save writes the selected domain's seconds and nanoseconds, as they stood just before the write's clock edge, into the staging registers 0x02..0x04 together.
- R10: A delta adds the staging nanoseconds register, read as a signed 32-bit value, to the selected domain on top of that cycle's increment. It borrows from or carries into seconds when the result leaves 0..999,999,999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| tod_sec_o | output | 144 | Seconds of each domain, 48 bits per domain |
| tod_ns_o | output | 90 | Nanoseconds of each domain, 30 bits per domain |

## Verification
The fractional remainder and the carries at the one-second and 32-bit seconds boundaries are visible only with exact cycle counting. The bench therefore issues a load and then saves separated by a known number of idle cycles, and predicts each captured value as the loaded time plus that many increments. A delta that lands in the same cycle as an increment is reached by loading, writing the delta, and issuing the delta command back to back on a running domain. The negative-offset load codes are driven straight into the staging register, because the counter never produces them itself.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,
    ACT_LOAD  = 3'd1,
    ACT_SAVE  = 3'd2,
    ACT_CLOCK = 3'd3,
    ACT_DELTA = 3'd4,
    ACT_TOD   = 3'd5
  } pin_act_e;

  localparam int INC_W  = 64;
  localparam int FRAC_W = 59;
  localparam int NS_W   = 30;
  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

  localparam int A_CTRL   = 0;
  localparam int A_CMD    = 1;
  localparam int A_SEC_HI = 2;
  localparam int A_SEC_LO = 3;
  localparam int A_NS     = 4;
  localparam int A_INC    = 8;
endpackage

// File: rtl/tod_inc_reg.sv
module tod_inc_reg
  import tod_pkg::*;
#(
  parameter logic [INC_W-1:0] NOM_INC = 64'h0FF8_0000_0000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_lo_i,
  input  logic             we_hi_i,
  input  logic [31:0]      wdata_i,
  input  logic             hold_i,
  output logic [INC_W-1:0] shadow_o,
  output logic [INC_W-1:0] active_o
);
  logic [INC_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= NOM_INC;
      active_q <= NOM_INC;
    end else begin
      if (we_lo_i) shadow_q[31:0] <= wdata_i;
      if (we_hi_i) shadow_q[63:32] <= wdata_i;
      if (!hold_i) active_q <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

  a_r5_hold_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(active_q));
  a_r5_release_applies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> active_q == $past(shadow_q));
endmodule

// File: rtl/tod_domain.sv
module tod_domain
  import tod_pkg::*;
#(
  parameter int SEC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_sec_i,
  input  logic [31:0]      load_ns_i,
  input  logic             delta_i,
  input  logic [31:0]      delta_ns_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o
);
  localparam int INT_W = INC_W - FRAC_W;
  localparam int SUM_W = NS_W + 4;
  localparam logic signed [SUM_W-1:0] NS_SEC_S = SUM_W'(NS_PER_SEC);
  localparam logic [NS_W-1:0] NEG_BASE = 30'd999_999_984;

  logic [SEC_W-1:0]  sec_q, sec_nxt, ld_sec;
  logic [NS_W-1:0]   ns_q, ns_nxt, ld_ns;
  logic [FRAC_W-1:0] frac_q, frac_nxt;
  logic [FRAC_W:0]   frac_sum;
  logic [INT_W:0]    step;
  logic signed [SUM_W-1:0] ns_ext, step_ext, delta_ext, ns_sum, ns_fix;

  always_comb begin
    frac_sum  = {1'b0, frac_q} + {1'b0, inc_i[FRAC_W-1:0]};
    step      = en_i ? ({1'b0, inc_i[INC_W-1:FRAC_W]} + {{INT_W{1'b0}}, frac_sum[FRAC_W]}) : '0;
    frac_nxt  = en_i ? frac_sum[FRAC_W-1:0] : frac_q;
    ns_ext    = $signed({{(SUM_W-NS_W){1'b0}}, ns_q});
    step_ext  = $signed({{(SUM_W-INT_W-1){1'b0}}, step});
    delta_ext = delta_i ? $signed({{(SUM_W-32){delta_ns_i[31]}}, delta_ns_i}) : '0;
    ns_sum    = ns_ext + step_ext + delta_ext;
    if (ns_sum[SUM_W-1]) begin
      ns_fix  = ns_sum + NS_SEC_S;
      sec_nxt = sec_q - 1'b1;
    end else if (ns_sum >= NS_SEC_S) begin
      ns_fix  = ns_sum - NS_SEC_S;
      sec_nxt = sec_q + 1'b1;
    end else begin
      ns_fix  = ns_sum;
      sec_nxt = sec_q;
    end
    ns_nxt = ns_fix[NS_W-1:0];
  end

  // load path: negative-offset codes and out-of-range clamp
  always_comb begin
    ld_sec = load_sec_i;
    if (load_ns_i[31:4] == 28'h3FF_FFFF) begin
      ld_sec = load_sec_i - 1'b1;
      ld_ns  = NEG_BASE + {26'd0, load_ns_i[3:0]};
    end else if (load_ns_i >= {2'b00, NS_PER_SEC}) begin
      ld_ns  = NS_PER_SEC - 1'b1;
    end else begin
      ld_ns  = load_ns_i[NS_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_i) begin
      sec_q  <= ld_sec;
      ns_q   <= ld_ns;
      frac_q <= '0;
    end else begin
      sec_q  <= sec_nxt;
      ns_q   <= ns_nxt;
      frac_q <= frac_nxt;
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;

  a_r3_ns_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_q < NS_PER_SEC);
  a_r3_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && !delta_i) |=>
      ((ns_q >= $past(ns_q)) ? (sec_q == $past(sec_q)) : (sec_q == $past(sec_q) + 1'b1)));
  a_r4_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i && !delta_i) |=> ($stable(ns_q) && $stable(sec_q) && $stable(frac_q)));
  a_r7_frac_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> frac_q == '0);
endmodule

// File: rtl/tod_pin.sv
module tod_pin
  import tod_pkg::*;
#(
  parameter int N_DOM = 3,
  parameter int SEC_W = 48
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_we_i,
  input  logic                        sec_hi_we_i,
  input  logic                        sec_lo_we_i,
  input  logic                        ns_we_i,
  input  logic [31:0]                 wdata_i,
  input  logic [N_DOM-1:0][SEC_W-1:0] snap_sec_i,
  input  logic [N_DOM-1:0][NS_W-1:0]  snap_ns_i,
  output logic [31:0]                 cmd_o,
  output logic [SEC_W-1:0]            pin_sec_o,
  output logic [31:0]                 pin_ns_o,
  output logic [N_DOM-1:0]            load_o,
  output logic [N_DOM-1:0]            delta_o
);
  pin_act_e         act_q, new_act;
  logic [1:0]       dom_q, new_dom;
  logic             sync_q, dom_ok, save_fire;
  logic [SEC_W-1:0] pin_sec_q, snap_sec_sel;
  logic [31:0]      pin_ns_q;
  logic [NS_W-1:0]  snap_ns_sel;

  always_comb begin
    new_act      = pin_act_e'(wdata_i[2:0]);
    new_dom      = wdata_i[5:4];
    dom_ok       = {30'd0, new_dom} < N_DOM;
    save_fire    = cmd_we_i && (new_act == ACT_SAVE) && dom_ok;
    snap_sec_sel = '0;
    snap_ns_sel  = '0;
    for (int d = 0; d < N_DOM; d++) begin
      if ({30'd0, new_dom} == d) begin
        snap_sec_sel = snap_sec_i[d];
        snap_ns_sel  = snap_ns_i[d];
      end
    end
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_fire
    assign load_o[d]  = cmd_we_i && (new_act == ACT_LOAD) && (act_q == ACT_IDLE)
                        && ({30'd0, new_dom} == d);
    assign delta_o[d] = cmd_we_i && (new_act == ACT_DELTA) && ({30'd0, new_dom} == d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= ACT_IDLE;
      dom_q     <= '0;
      sync_q    <= 1'b0;
      pin_sec_q <= '0;
      pin_ns_q  <= '0;
    end else begin
      if (cmd_we_i) begin
        act_q  <= new_act;
        dom_q  <= new_dom;
        sync_q <= wdata_i[8];
      end
      if (save_fire) begin
        pin_sec_q <= snap_sec_sel;
        pin_ns_q  <= {{(32-NS_W){1'b0}}, snap_ns_sel};
      end else begin
        if (sec_hi_we_i) pin_sec_q[SEC_W-1:32] <= wdata_i[SEC_W-33:0];
        if (sec_lo_we_i) pin_sec_q[31:0] <= wdata_i;
        if (ns_we_i)     pin_ns_q <= wdata_i;
      end
    end
  end

  assign cmd_o     = {23'd0, sync_q, 2'b00, dom_q, 1'b0, act_q};
  assign pin_sec_o = pin_sec_q;
  assign pin_ns_o  = pin_ns_q;

  a_r9_save_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_fire |=> (pin_sec_q == $past(snap_sec_sel))
                  && (pin_ns_q == {{(32-NS_W){1'b0}}, $past(snap_ns_sel)}));
  a_r6_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_o, delta_o}));
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import tod_pkg::*;
#(
  parameter int               N_DOM   = 3,
  parameter int               SEC_W   = 48,
  parameter int               ADDR_W  = 5,
  parameter logic [INC_W-1:0] NOM_INC = 64'h0FF8_0000_0000_0000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [31:0]                 wr_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [31:0]                 rd_data_o,
  output logic [N_DOM-1:0][SEC_W-1:0] tod_sec_o,
  output logic [N_DOM-1:0][NS_W-1:0]  tod_ns_o
);
  localparam int HOLD_LSB = 8;

  logic [N_DOM-1:0]             ena_q, hold_q, load, delta;
  logic [N_DOM-1:0][INC_W-1:0]  inc_shadow, inc_active;
  logic [31:0]                  cmd_word, pin_ns;
  logic [SEC_W-1:0]             pin_sec;
  logic                         ctrl_we, cmd_we, sec_hi_we, sec_lo_we, ns_we;

  assign ctrl_we   = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
  assign cmd_we    = wr_en_i && (wr_addr_i == ADDR_W'(A_CMD));
  assign sec_hi_we = wr_en_i && (wr_addr_i == ADDR_W'(A_SEC_HI));
  assign sec_lo_we = wr_en_i && (wr_addr_i == ADDR_W'(A_SEC_LO));
  assign ns_we     = wr_en_i && (wr_addr_i == ADDR_W'(A_NS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q  <= '0;
      hold_q <= '0;
    end else if (ctrl_we) begin
      ena_q  <= wr_data_i[N_DOM-1:0];
      hold_q <= wr_data_i[HOLD_LSB+N_DOM-1:HOLD_LSB];
    end
  end

  tod_pin #(.N_DOM(N_DOM), .SEC_W(SEC_W)) i_pin (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we),
    .sec_hi_we_i (sec_hi_we),
    .sec_lo_we_i (sec_lo_we),
    .ns_we_i     (ns_we),
    .wdata_i     (wr_data_i),
    .snap_sec_i  (tod_sec_o),
    .snap_ns_i   (tod_ns_o),
    .cmd_o       (cmd_word),
    .pin_sec_o   (pin_sec),
    .pin_ns_o    (pin_ns),
    .load_o      (load),
    .delta_o     (delta)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic we_lo, we_hi;
    assign we_lo = wr_en_i && (wr_addr_i == ADDR_W'(A_INC + 2*d));
    assign we_hi = wr_en_i && (wr_addr_i == ADDR_W'(A_INC + 2*d + 1));

    tod_inc_reg #(.NOM_INC(NOM_INC)) i_inc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_lo_i  (we_lo),
      .we_hi_i  (we_hi),
      .wdata_i  (wr_data_i),
      .hold_i   (hold_q[d]),
      .shadow_o (inc_shadow[d]),
      .active_o (inc_active[d])
    );

    tod_domain #(.SEC_W(SEC_W)) i_domain (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (ena_q[d]),
      .inc_i      (inc_active[d]),
      .load_i     (load[d]),
      .load_sec_i (pin_sec),
      .load_ns_i  (pin_ns),
      .delta_i    (delta[d]),
      .delta_ns_i (pin_ns),
      .sec_o      (tod_sec_o[d]),
      .ns_o       (tod_ns_o[d])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(A_CTRL)) begin
      rd_data_o[N_DOM-1:0] = ena_q;
      rd_data_o[HOLD_LSB+N_DOM-1:HOLD_LSB] = hold_q;
    end
    if (rd_addr_i == ADDR_W'(A_CMD))    rd_data_o = cmd_word;
    if (rd_addr_i == ADDR_W'(A_SEC_HI)) rd_data_o = {{(64-SEC_W){1'b0}}, pin_sec[SEC_W-1:32]};
    if (rd_addr_i == ADDR_W'(A_SEC_LO)) rd_data_o = pin_sec[31:0];
    if (rd_addr_i == ADDR_W'(A_NS))     rd_data_o = pin_ns;
    for (int d = 0; d < N_DOM; d++) begin
      if (rd_addr_i == ADDR_W'(A_INC + 2*d))     rd_data_o = inc_shadow[d][31:0];
      if (rd_addr_i == ADDR_W'(A_INC + 2*d + 1)) rd_data_o = inc_shadow[d][63:32];
    end
  end

  a_r4_stopped_domain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena_q[0] && !load[0] && !delta[0]) |=> $stable(tod_ns_o[0]));
endmodule

// File: tb/test_ptp_tod_core.sv
module test_ptp_tod_core;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [4:0]        wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [4:0]        rd_addr = '0;
  logic [31:0]       rd_data;
  logic [2:0][47:0]  tod_sec;
  logic [2:0][29:0]  tod_ns;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptp_tod_core i_ptp_tod_core (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tod_sec_o(tod_sec), .tod_ns_o(tod_ns)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next one
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_inc(input int dom, input logic [63:0] v);
    wr(5'(8 + 2*dom), v[31:0]);
    wr(5'(9 + 2*dom), v[63:32]);
  endtask

  task automatic load(input int dom, input logic [47:0] s, input logic [31:0] ns);
    wr(5'd2, {16'd0, s[47:32]});
    wr(5'd3, s[31:0]);
    wr(5'd4, ns);
    wr(5'd1, 32'(dom << 4));
    wr(5'd1, 32'((dom << 4) | 1));
  endtask

  task automatic save_chk(input string tag, input int dom, input logic [47:0] es, input logic [29:0] ens);
    logic [31:0] hi, lo, ns;
    wr(5'd1, 32'((dom << 4) | 2));
    rd(5'd2, hi); rd(5'd3, lo); rd(5'd4, ns);
    chk({tag, " sec"}, {hi[15:0], lo}, es);
    chk({tag, " ns"}, ns, {2'b00, ens});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(5'd0, v); chk("R1 ctrl", v, 0);
    rd(5'd1, v); chk("R1 cmd", v, 0);
    rd(5'd8, v); chk("R1 inc lo", v, 0);
    rd(5'd9, v); chk("R1 inc hi", v, 32'h0FF8_0000);
    chk("R1 ns", tod_ns[1], 0);
    save_chk("R1 save", 0, 0, 0);
  endtask

  task automatic t_frac;
    set_inc(0, 64'h1400_0000_0000_0000);
    wr(5'd0, 32'h1);
    load(0, 0, 0);
    idle(3);
    save_chk("R2 frac 3cyc", 0, 0, 7);
    save_chk("R2 frac 4cyc", 0, 0, 10);
  endtask

  task automatic t_wrap;
    set_inc(0, 64'h4000_0000_0000_0000);
    idle(2);
    load(0, 5, 999_999_990);
    idle(1);
    save_chk("R3 before wrap", 0, 5, 999_999_998);
    save_chk("R3 wrap", 0, 6, 6);
    load(0, 48'h1234_FFFF_FFFF, 999_999_999);
    idle(1);
    save_chk("R3 carry 32b", 0, 48'h1235_0000_0000, 7);
  endtask

  task automatic t_enable;
    set_inc(1, 64'h4000_0000_0000_0000);
    wr(5'd0, 32'h2);
    load(0, 0, 100);
    load(1, 0, 100);
    idle(5);
    save_chk("R4 stopped dom0", 0, 0, 100);
    save_chk("R4 R9 running dom1", 1, 0, 148);
    chk("R4 dom2 untouched", tod_ns[2], 0);
  endtask

  task automatic t_stage;
    logic [31:0] v;
    wr(5'd0, 32'h101);
    set_inc(0, 64'h8000_0000_0000_0000);
    rd(5'd9, v); chk("R5 staged readback", v, 32'h8000_0000);
    load(0, 0, 0);
    idle(4);
    save_chk("R5 held rate", 0, 0, 32);
    wr(5'd0, 32'h1);
    idle(2);
    load(0, 0, 0);
    idle(4);
    save_chk("R5 released rate", 0, 0, 64);
  endtask

  task automatic t_cmd_rules;
    logic [31:0] v;
    wr(5'd0, 32'h0);
    load(0, 7, 300);
    save_chk("R7 load", 0, 7, 300);
    wr(5'd3, 9); wr(5'd4, 555);
    wr(5'd1, 32'h1);
    save_chk("R7 load not after idle", 0, 7, 300);
    wr(5'd3, 9); wr(5'd4, 555);
    wr(5'd1, 32'h30);
    wr(5'd1, 32'h31);
    chk("R6 dom3 ignored", tod_ns[0], 300);
    wr(5'd1, 32'h103);
    wr(5'd1, 32'h105);
    rd(5'd1, v); chk("R6 cmd readback", v, 32'h105);
    save_chk("R6 clock/tod no effect", 0, 7, 300);
  endtask

  task automatic t_negcode;
    load(0, 10, 32'h3FFF_FFF5);
    save_chk("R8 neg code", 0, 9, 999_999_989);
  endtask

  task automatic t_delta;
    load(2, 20, 100);
    wr(5'd4, 32'hFFFF_FF38);
    wr(5'd1, 32'h24);
    save_chk("R10 neg borrow", 2, 19, 999_999_900);
    load(2, 20, 999_999_000);
    wr(5'd4, 5000);
    wr(5'd1, 32'h24);
    save_chk("R10 pos carry", 2, 21, 4000);
    set_inc(0, 64'h4000_0000_0000_0000);
    wr(5'd0, 32'h1);
    load(0, 0, 1000);
    wr(5'd4, 100);
    wr(5'd1, 32'h04);
    save_chk("R10 with increment", 0, 0, 1116);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_frac();
    t_wrap();
    t_enable();
    t_stage();
    t_cmd_rules();
    t_negcode();
    t_delta();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule